// File: doc/BRIEF.md
# Multi-Channel Programmable Input Debouncer

The block watches up to eight asynchronous external lines and reports, per line, when that line has settled at its active level for a programmable number of milliseconds. Every line first passes through a two-flop synchroniser. A per-channel state machine then counts millisecond ticks while the synchronised line stays at its active level. Any change of the line restarts the count. When the window has elapsed, the channel sets a sticky status bit. Software clears that bit by writing a one to it.

The millisecond tick comes from a 32.768 kHz reference that is sampled in the system clock domain. A prescaler runs periods of 32 and 33 reference cycles, and a fractional accumulator picks the mix so that the average is exactly 32.768 cycles per tick. The prescaler runs only while some channel is counting. The clock-enable output reports that same condition, so a clock gate outside the block can stop the counting clock whenever every channel is idle.

Each channel runs in one of two modes. In single-trigger mode a channel reports one event per qualified transition and stays silent until software clears its status. In continuous mode a line held at its active level reports again after every further window. A masked OR of the status bits drives one interrupt line.

Top module: `dbnc_array`

## Requirements
- R1: After reset the status is 0, `irq` and `clk_en` are 0, and the control register and every window register read 0.
- R2: A channel's synchronised line that leaves the active level restarts that channel's count. An active pulse shorter than 1 ms (32 reference cycles) never sets status.
- R3: The window is N ms with N = the channel's window register. Status sets no earlier than N ms after the last change of the line, and no later than N+1 ms plus a few clock cycles of synchroniser latency. One ms is 32.768 reference cycles on average.
- R4: The window registers are 12 bits wide: bits above bit 11 read as 0. A window value of 0 behaves as 1 ms.
- R5: Polarity bit = 0 makes a stable high level qualify. Polarity bit = 1 makes a stable low level qualify.
- R6: A channel whose enable bit is 0 never sets its status bit, whatever its input does.
- R7: Single-trigger mode (mode bit = 1): a qualified channel fires once. Clearing its status while the line is still held does not produce a new event. A new transition is needed, and the clear rearms the channel for it.
- R8: Continuous mode (mode bit = 0): while the line stays active, the channel fires again after each further window, so a status cleared during the hold sets again.
- R9: Writing the status address clears exactly the bits written as 1. Bits written as 0 are unchanged. Status bits change no other way except by being set.
- R10: `irq` is 1 exactly when some status bit is set whose mask bit is 1.
- R11: `clk_en` is 1 while any enabled channel is counting (a pending window, or a held line in continuous mode). It is 0 when every channel is idle, disabled, or held in single-trigger mode.
- R12: Register map: address 0 holds enable in bits [7:0], polarity in [15:8] and mode in [23:16]. Address 1 holds the mask in [7:0]. Address 2 holds the status in [7:0] and is write-one-to-clear. Address 8+c holds channel c's window in [11:0]. Reads are combinational from `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | 32.768 kHz reference, asynchronous |
| sense_i | input | CH | Raw external lines, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | DW | Register read data |
| irq | output | 1 | Masked OR of status bits |
| clk_en | output | 1 | Counting clock request |

## Verification
Faults in a channel's count or state show up as a status bit that sets earlier or later than its window allows. They also show up as a bit that sets again in single-trigger mode after a clear, or that fails to set again in continuous mode. The bench brackets each event between the earliest and latest legal cycle, and a one-window error in the count or prescaler lands outside that bracket within a few milliseconds. A stuck state machine also shows at once on `clk_en`. That output is checked right after each idle, held and counting transition.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

    localparam int unsigned WIN_W   = 12;
    localparam int unsigned ADDR_W  = 4;
    localparam int unsigned FIELD_W = 8;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] A_MASK = 4'h1;
    localparam logic [ADDR_W-1:0] A_STAT = 4'h2;
    localparam logic [ADDR_W-1:0] A_WIN0 = 4'h8;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_COUNT = 2'd1,
        S_HELD  = 2'd2
    } chan_state_e;

    typedef struct packed {
        logic en;
        logic pol_low;
        logic single;
    } chan_cfg_t;

    function automatic logic [WIN_W-1:0] eff_window(input logic [WIN_W-1:0] w);
        return (w == '0) ? WIN_W'(1) : w;
    endfunction

endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/dbnc_tick.sv
module dbnc_tick #(
    parameter int unsigned REF_INT  = 32,
    parameter int unsigned FRAC_NUM = 768,
    parameter int unsigned FRAC_DEN = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ref_rise,
    output logic tick
);
    localparam int unsigned PW  = $clog2(REF_INT + 1);
    localparam int unsigned ACW = $clog2(2 * FRAC_DEN + 1);
    localparam logic [ACW-1:0] NUM_C = ACW'(FRAC_NUM);
    localparam logic [ACW-1:0] DEN_C = ACW'(FRAC_DEN);

    logic [PW-1:0]  cnt_q;
    logic [ACW-1:0] acc_q;
    logic           tick_q;
    logic [ACW-1:0] acc_sum;
    logic           long_ms;
    logic [PW-1:0]  last_cnt;

    // a long period (one extra reference cycle) whenever the fraction wraps
    assign acc_sum  = acc_q + NUM_C;
    assign long_ms  = (acc_sum >= DEN_C);
    assign last_cnt = long_ms ? PW'(REF_INT) : PW'(REF_INT - 1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q  <= '0;
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (ref_rise) begin
                if (cnt_q == last_cnt) begin
                    cnt_q  <= '0;
                    tick_q <= 1'b1;
                    acc_q  <= long_ms ? (acc_sum - DEN_C) : acc_sum;
                end else begin
                    cnt_q <= cnt_q + PW'(1);
                end
            end
        end
    end

    assign tick = tick_q;
endmodule

// File: rtl/dbnc_chan.sv
module dbnc_chan
    import dbnc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  chan_cfg_t        cfg,
    input  logic [WIN_W-1:0] win,
    input  logic             lvl,
    input  logic             tick,
    input  logic             rearm,
    output logic             fire,
    output logic             counting
);
    chan_state_e      st_q;
    logic [WIN_W-1:0] cnt_q;
    logic             armed_q;
    logic             fire_q;
    logic             act;
    logic             hit;
    logic             may_fire;
    logic [WIN_W-1:0] lim;

    assign act      = lvl ^ cfg.pol_low;
    assign lim      = eff_window(win);
    // window is met on the tick that finds N full ticks already counted
    assign hit      = tick && (cnt_q >= lim);
    assign may_fire = !cfg.single || armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            cnt_q   <= '0;
            armed_q <= 1'b1;
            fire_q  <= 1'b0;
        end else begin
            fire_q <= 1'b0;
            if (rearm) begin
                armed_q <= 1'b1;
            end
            if (!cfg.en) begin
                st_q  <= S_IDLE;
                cnt_q <= '0;
            end else begin
                case (st_q)
                    S_IDLE: begin
                        cnt_q <= '0;
                        if (act) begin
                            st_q <= S_COUNT;
                        end
                    end
                    S_COUNT: begin
                        if (!act) begin
                            st_q  <= S_IDLE;
                            cnt_q <= '0;
                        end else if (hit) begin
                            st_q  <= S_HELD;
                            cnt_q <= '0;
                            if (may_fire) begin
                                fire_q <= 1'b1;
                                if (cfg.single) begin
                                    armed_q <= 1'b0;
                                end
                            end
                        end else if (tick) begin
                            cnt_q <= cnt_q + WIN_W'(1);
                        end
                    end
                    S_HELD: begin
                        if (!act) begin
                            st_q  <= S_IDLE;
                            cnt_q <= '0;
                        end else if (!cfg.single) begin
                            if (hit) begin
                                cnt_q  <= '0;
                                fire_q <= 1'b1;
                            end else if (tick) begin
                                cnt_q <= cnt_q + WIN_W'(1);
                            end
                        end
                    end
                    default: begin
                        st_q  <= S_IDLE;
                        cnt_q <= '0;
                    end
                endcase
            end
        end
    end

    assign fire     = fire_q;
    assign counting = cfg.en && ((st_q == S_COUNT) || ((st_q == S_HELD) && !cfg.single));
endmodule

// File: rtl/dbnc_regs.sv
module dbnc_regs
    import dbnc_pkg::*;
#(
    parameter int unsigned CH = 8,
    parameter int unsigned DW = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DW-1:0]              wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [CH-1:0]              fire,
    output logic [DW-1:0]              rd_data,
    output chan_cfg_t [CH-1:0]         cfg,
    output logic [CH-1:0][WIN_W-1:0]   win,
    output logic [CH-1:0]              mask,
    output logic [CH-1:0]              stat,
    output logic [CH-1:0]              clr
);
    logic [CH-1:0]            en_q, pol_q, sgl_q, mask_q, stat_q;
    logic [CH-1:0][WIN_W-1:0] win_q;

    assign clr = (wr_en && (wr_addr == A_STAT)) ? wr_data[CH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pol_q  <= '0;
            sgl_q  <= '0;
            mask_q <= '0;
            stat_q <= '0;
        end else begin
            if (wr_en && (wr_addr == A_CTRL)) begin
                en_q  <= wr_data[0 +: CH];
                pol_q <= wr_data[FIELD_W +: CH];
                sgl_q <= wr_data[2*FIELD_W +: CH];
            end
            if (wr_en && (wr_addr == A_MASK)) begin
                mask_q <= wr_data[CH-1:0];
            end
            // a new event wins over a clear in the same cycle
            stat_q <= (stat_q & ~clr) | fire;
        end
    end

    for (genvar c = 0; c < CH; c++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                win_q[c] <= '0;
            end else if (wr_en && (wr_addr == A_WIN0 + ADDR_W'(c))) begin
                win_q[c] <= wr_data[WIN_W-1:0];
            end
        end
        assign cfg[c] = '{en: en_q[c], pol_low: pol_q[c], single: sgl_q[c]};
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL) begin
            rd_data[0 +: CH]         = en_q;
            rd_data[FIELD_W +: CH]   = pol_q;
            rd_data[2*FIELD_W +: CH] = sgl_q;
        end else if (rd_addr == A_MASK) begin
            rd_data[CH-1:0] = mask_q;
        end else if (rd_addr == A_STAT) begin
            rd_data[CH-1:0] = stat_q;
        end else begin
            for (int c = 0; c < CH; c++) begin
                if (rd_addr == A_WIN0 + ADDR_W'(c)) begin
                    rd_data[WIN_W-1:0] = win_q[c];
                end
            end
        end
    end

    assign win  = win_q;
    assign mask = mask_q;
    assign stat = stat_q;
endmodule

// File: rtl/dbnc_array.sv
module dbnc_array
    import dbnc_pkg::*;
#(
    parameter int unsigned CH       = 8,
    parameter int unsigned DW       = 32,
    parameter int unsigned REF_INT  = 32,
    parameter int unsigned FRAC_NUM = 768,
    parameter int unsigned FRAC_DEN = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_clk,
    input  logic [CH-1:0]     sense_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              irq,
    output logic              clk_en
);
    logic [CH-1:0]            lvl;
    logic                     ref_s, ref_d;
    logic                     ref_rise;
    logic                     tick;
    logic                     busy;
    chan_cfg_t [CH-1:0]       cfg;
    logic [CH-1:0][WIN_W-1:0] win;
    logic [CH-1:0]            mask_vec, stat_vec, clr_vec, fire_vec, cnt_vec, en_vec;

    dbnc_sync #(.W(CH)) u_in_sync (.clk(clk), .rst(rst), .d(sense_i), .q(lvl));
    dbnc_sync #(.W(1))  u_ref_sync (.clk(clk), .rst(rst), .d(ref_clk), .q(ref_s));

    always_ff @(posedge clk) begin
        if (rst) ref_d <= 1'b0;
        else     ref_d <= ref_s;
    end
    assign ref_rise = ref_s & ~ref_d;

    dbnc_tick #(.REF_INT(REF_INT), .FRAC_NUM(FRAC_NUM), .FRAC_DEN(FRAC_DEN)) u_tick (
        .clk(clk), .rst(rst), .run(busy), .ref_rise(ref_rise), .tick(tick)
    );

    dbnc_regs #(.CH(CH), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .fire(fire_vec), .rd_data(rd_data), .cfg(cfg), .win(win),
        .mask(mask_vec), .stat(stat_vec), .clr(clr_vec)
    );

    for (genvar c = 0; c < CH; c++) begin : g_ch
        dbnc_chan u_chan (
            .clk(clk), .rst(rst), .cfg(cfg[c]), .win(win[c]), .lvl(lvl[c]),
            .tick(tick), .rearm(clr_vec[c]), .fire(fire_vec[c]), .counting(cnt_vec[c])
        );
        assign en_vec[c] = cfg[c].en;
    end

    assign busy   = |cnt_vec;
    assign clk_en = busy;
    assign irq    = |(stat_vec & mask_vec);
endmodule

// File: rtl/dbnc_array_chk.sv
module dbnc_array_chk
    import dbnc_pkg::*;
#(
    parameter int unsigned CH = 8,
    parameter int unsigned DW = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DW-1:0]     rd_data,
    input logic              clk_en,
    input logic              tick,
    input logic [CH-1:0]     stat_vec,
    input logic [CH-1:0]     en_vec
);
    // R9: a status bit only drops in the cycle after a status write
    a_r9_clear_only_by_write: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wr_addr == A_STAT)) |=> (($past(stat_vec) & ~stat_vec) == '0));

    // R6: newly set status bits belong to enabled channels
    a_r6_disabled_never_sets: assert property (@(posedge clk) disable iff (rst)
        ((stat_vec & ~$past(stat_vec) & ~$past(en_vec, 2)) == '0));

    // R11: the prescaler only ticks while the counting clock is requested
    a_r11_tick_needs_clk_en: assert property (@(posedge clk) disable iff (rst)
        tick |-> $past(clk_en));

    // R4: window registers read back with zero upper bits
    a_r4_window_width: assert property (@(posedge clk) disable iff (rst)
        (rd_addr >= A_WIN0) |-> (rd_data[DW-1:WIN_W] == '0));
endmodule

bind dbnc_array dbnc_array_chk #(.CH(CH), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .rd_data(rd_data), .clk_en(clk_en), .tick(tick), .stat_vec(stat_vec), .en_vec(en_vec)
);

// File: tb/dbnc_array_tb_top.sv
module dbnc_array_tb_top;
    localparam int CH    = 8;
    localparam int DW    = 32;
    localparam int MS_LO = 256;   // 32 reference periods of 8 clocks
    localparam int MS_HI = 264;   // 33 reference periods of 8 clocks

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_clk = 1'b0;
    logic [CH-1:0] sense = '0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [3:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          irq, clk_en;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [7:0] en_s = '0, pol_s = '0, sgl_s = '0;

    dbnc_array #(.CH(CH), .DW(DW)) dut_i (
        .clk(clk), .rst(rst), .ref_clk(ref_clk), .sense_i(sense), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq), .clk_en(clk_en)
    );

    always #2.5 clk = ~clk;
    always #20 ref_clk = ~ref_clk;

    function automatic int eff(input int w);
        return (w == 0) ? 1 : w;
    endfunction
    function automatic int t_min(input int n);
        return n * MS_LO - 16;
    endfunction
    function automatic int t_max(input int n);
        return (n + 1) * MS_HI + 32;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wr_ctrl();
        wr(4'h0, {8'h0, sgl_s, pol_s, en_s});
    endtask

    task automatic stat_bit(input int c, output logic b);
        logic [31:0] d;
        rd(4'h2, d);
        b = d[c];
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // input was just driven active on a negedge: bracket the event
    task automatic timed_event(input int c, input int n, input string req);
        logic b;
        wait_clk(t_min(n) - 2);
        stat_bit(c, b);
        chk(req, b, 1'b0);
        chk("R11", clk_en, 1'b1);
        wait_clk(t_max(n) - t_min(n));
        stat_bit(c, b);
        chk(req, b, 1'b1);
    endtask

    initial begin
        logic [31:0] d;
        logic b;
        int sd;
        sd = $urandom(32'h5eed);
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);

        // R1 reset state
        rd(4'h2, d); chk("R1", d, 32'h0);
        chk("R1", irq, 1'b0);
        chk("R1", clk_en, 1'b0);
        rd(4'h0, d); chk("R1", d, 32'h0);
        rd(4'h8, d); chk("R1", d, 32'h0);

        // R4 / R12 window register width
        wr(4'h9, 32'hFFFF_FFFF);
        rd(4'h9, d); chk("R4", d, 32'h0000_0FFF);
        wr(4'hF, 32'h0000_0ABC);
        rd(4'hF, d); chk("R12", d, 32'h0000_0ABC);

        // R3 / R8 / R10: channel 0, high active, continuous, window 2
        wr(4'h1, 32'hFF);
        wr(4'h8, 32'd2);
        en_s = 8'h01; wr_ctrl();
        @(negedge clk); sense[0] = 1'b1;
        timed_event(0, 2, "R3");
        chk("R10", irq, 1'b1);
        wr(4'h2, 32'h0);
        stat_bit(0, b); chk("R9", b, 1'b1);
        wr(4'h1, 32'h0);
        chk("R10", irq, 1'b0);
        wr(4'h1, 32'hFF);
        wr(4'h2, 32'h1);
        stat_bit(0, b); chk("R9", b, 1'b0);
        wait_clk(t_max(2));
        stat_bit(0, b); chk("R8", b, 1'b1);
        chk("R11", clk_en, 1'b1);
        sense[0] = 1'b0;
        wait_clk(6);
        chk("R11", clk_en, 1'b0);
        wr(4'h2, 32'h1);

        // R2: glitch train restarts the count
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); sense[0] = 1'b1;
            wait_clk(100 + ($urandom % 300));
            sense[0] = 1'b0;
            wait_clk(3 + ($urandom % 18));
        end
        sense[0] = 1'b1;
        timed_event(0, 2, "R2");
        sense[0] = 1'b0;
        wait_clk(6);
        wr(4'h2, 32'h1);

        // R2: random short pulses below 1 ms on window 1
        wr(4'h8, 32'd1);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk); sense[0] = 1'b1;
            wait_clk(1 + ($urandom % 240));
            sense[0] = 1'b0;
            wait_clk(20 + ($urandom % 100));
        end
        stat_bit(0, b); chk("R2", b, 1'b0);
        en_s = 8'h00; wr_ctrl();

        // R5 / R7: channel 1, low active, single trigger, window 1
        sense[1] = 1'b1;
        wr(4'h9, 32'd1);
        en_s = 8'h02; pol_s = 8'h02; sgl_s = 8'h02; wr_ctrl();
        wait_clk(10);
        chk("R5", clk_en, 1'b0);
        sense[1] = 1'b0;
        timed_event(1, 1, "R5");
        wait_clk(4);
        chk("R11", clk_en, 1'b0);
        wr(4'h2, 32'h2);
        wait_clk(2 * t_max(1));
        stat_bit(1, b); chk("R7", b, 1'b0);
        sense[1] = 1'b1;
        wait_clk(10);
        sense[1] = 1'b0;
        timed_event(1, 1, "R7");
        sense[1] = 1'b1;
        en_s = 8'h00; pol_s = 8'h00; sgl_s = 8'h00; wr_ctrl();
        wr(4'h2, 32'hFF);

        // R4: window 0 behaves as 1 ms on channel 2
        wr(4'hA, 32'd0);
        en_s = 8'h04; wr_ctrl();
        @(negedge clk); sense[2] = 1'b1;
        timed_event(2, 1, "R4");
        sense[2] = 1'b0;
        en_s = 8'h00; wr_ctrl();
        wr(4'h2, 32'hFF);

        // R6: disabled channel 3 held active
        @(negedge clk); sense[3] = 1'b1;
        wait_clk(3 * t_max(1));
        stat_bit(3, b); chk("R6", b, 1'b0);
        chk("R11", clk_en, 1'b0);
        chk("R6", irq, 1'b0);
        sense[3] = 1'b0;

        // R3 / R5 random windows and polarities on channels 4..7
        for (int k = 0; k < 6; k++) begin
            int c, n, p;
            c = 4 + ($urandom % 4);
            n = $urandom % 4;
            p = $urandom % 2;
            sense[c] = p[0];
            wr(4'(8 + c), 32'(n));
            en_s = 8'(1 << c); pol_s = p[0] ? 8'(1 << c) : 8'h00; sgl_s = 8'h00;
            wr_ctrl();
            wait_clk(10);
            sense[c] = ~p[0];
            timed_event(c, eff(n), "R3");
            sense[c] = p[0];
            wait_clk(6);
            en_s = 8'h00; pol_s = 8'h00; wr_ctrl();
            wr(4'h2, 32'hFF);
            sense[c] = 1'b0;
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule